// File: doc/BRIEF.md
# Banked Logical-Device Configuration Port

This block is the configuration front end of a legacy-style peripheral controller on an 8-bit I/O bus. It occupies two I/O addresses: an index port that picks a configuration register and a data port that reads or writes the register picked. After reset it is locked. While locked, data-port writes have no effect and reads return all ones. A fixed two-byte key written to the index port opens it, and a single lock byte closes it again.

Once the port is open, a logical-device-select register chooses one of nine configuration banks. Each bank holds one device's enable bit, 16-bit I/O base, interrupt number and interrupt polarity. Every bank is presented on the outputs all the time, so downstream device logic can be wired to it directly. The devices themselves are outside this block. Software sets up a device by opening the port, writing the device number to the select register, and then writing that bank's registers through the index and data ports.

Top module: `ldev_cfg_port`

## Requirements
- R1: After reset the port is locked, the index and device-select registers are 0x00, and every device's enable, base, interrupt number and polarity output is zero.
- R2: Only a write strobe at address 0x2E (index) or 0x2F (data) changes any state. A read at any other address returns 0x00.
- R3: Two consecutive index-port writes of 0xA5 open the port. Any other index byte written between the two keys restarts the sequence, so the port stays locked. The key bytes are not stored as an index.
- R4: While the port is open, writing 0xAA to the index port locks it. Any other index byte becomes the current index, and an index-port read returns that index.
- R5: While the port is locked, data-port writes change no register, and data-port and index-port reads both return 0xFF.
- R6: Register 0x07 is the logical-device select. It stores a full byte and reads back unchanged.
- R7: In the selected bank, register 0x30 bit 0 is the device enable. The other bits are discarded, and a read returns {7'b0, enable}.
- R8: In the selected bank, registers 0x60 and 0x61 hold bits 15:8 and 7:0 of the device's I/O base, and both read back.
- R9: In the selected bank, register 0x70 holds the 8-bit interrupt number. Register 0x71 bit 0 holds the polarity, where 1 means active-low level. A read of 0x71 returns {7'b0, polarity}.
- R10: Device numbers 0x02, 0x03, 0x04, 0x05, 0x07, 0x0B, 0x0C, 0x0D and 0x0E map to output slots 0 to 8 in that order. Slot j drives dev_en_o[j], dev_irq_low_o[j], dev_base_o[16j+15:16j] and dev_irq_num_o[8j+7:8j].
- R11: With an unimplemented device number selected, or for any register index other than 0x07, 0x30, 0x60, 0x61, 0x70 and 0x71, a data read returns 0x00 and a data write changes no output.
- R12: io_rdata_o is registered. It changes only at the clock edge that samples io_rd_i high and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_wr_i | input | 1 | Single-cycle I/O write strobe |
| io_rd_i | input | 1 | Single-cycle I/O read strobe |
| io_addr_i | input | ADDR_W | I/O address |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Registered read data |
| dev_en_o | output | NUM_DEV | Per-slot device enable |
| dev_base_o | output | 16*NUM_DEV | Per-slot I/O base |
| dev_irq_num_o | output | 8*NUM_DEV | Per-slot interrupt number |
| dev_irq_low_o | output | NUM_DEV | Per-slot active-low level interrupt select |

## Verification
A write strobe takes effect at the rising edge that samples it. The lock state, the index and all configuration outputs are therefore valid right after that edge. Read data is registered at the edge that samples io_rd_i and then holds, so each result is valid one edge after the strobe.

The bench drives every strobe for exactly one cycle from a falling edge. It samples outputs and read data at the next falling edge, which falls between the edge that updates them and the next access. The hold behaviour of the read data is checked by waiting idle cycles after a read.

// File: rtl/ldev_cfg_pkg.sv
package ldev_cfg_pkg;
  localparam int DATA_W  = 8;
  localparam int BASE_W  = 2 * DATA_W;
  localparam int IRQ_W   = DATA_W;
  localparam int NUM_DEV = 9;

  // ascending device numbers; position in list = output slot
  localparam logic [DATA_W-1:0] DEV_ID [NUM_DEV] = '{
    8'h02, 8'h03, 8'h04, 8'h05, 8'h07, 8'h0B, 8'h0C, 8'h0D, 8'h0E
  };

  localparam logic [DATA_W-1:0] REG_LDN      = 8'h07;
  localparam logic [DATA_W-1:0] REG_ENABLE   = 8'h30;
  localparam logic [DATA_W-1:0] REG_BASE_HI  = 8'h60;
  localparam logic [DATA_W-1:0] REG_BASE_LO  = 8'h61;
  localparam logic [DATA_W-1:0] REG_IRQ_NUM  = 8'h70;
  localparam logic [DATA_W-1:0] REG_IRQ_TYPE = 8'h71;

  localparam logic [DATA_W-1:0] KEY_OPEN    = 8'hA5;
  localparam logic [DATA_W-1:0] KEY_CLOSE   = 8'hAA;
  localparam logic [DATA_W-1:0] LOCKED_READ = 8'hFF;

  typedef enum logic [1:0] {
    GATE_LOCKED = 2'd0,
    GATE_HALF   = 2'd1,
    GATE_OPEN   = 2'd2
  } gate_state_e;

  typedef struct packed {
    logic              en;
    logic [BASE_W-1:0] base;
    logic [IRQ_W-1:0]  irq;
    logic              irq_low;
  } dev_cfg_t;
endpackage

// File: rtl/ldev_cfg_gate.sv
module ldev_cfg_gate
  import ldev_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              unlocked_o,
  output logic [DATA_W-1:0] index_o
);
  gate_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GATE_LOCKED;
      index_o <= '0;
    end else if (idx_wr_i) begin
      unique case (state_q)
        GATE_LOCKED: if (wdata_i == KEY_OPEN) state_q <= GATE_HALF;
        GATE_HALF:   state_q <= (wdata_i == KEY_OPEN) ? GATE_OPEN : GATE_LOCKED;
        GATE_OPEN: begin
          if (wdata_i == KEY_CLOSE) state_q <= GATE_LOCKED;
          else                      index_o <= wdata_i;
        end
        default:     state_q <= GATE_LOCKED;
      endcase
    end
  end

  assign unlocked_o = (state_q == GATE_OPEN);
endmodule

// File: rtl/ldev_cfg_bank.sv
module ldev_cfg_bank
  import ldev_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output dev_cfg_t          cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (wr_i) begin
      case (reg_i)
        REG_ENABLE:   cfg_o.en                      <= wdata_i[0];
        REG_BASE_HI:  cfg_o.base[BASE_W-1:DATA_W]   <= wdata_i;
        REG_BASE_LO:  cfg_o.base[DATA_W-1:0]        <= wdata_i;
        REG_IRQ_NUM:  cfg_o.irq                     <= wdata_i;
        REG_IRQ_TYPE: cfg_o.irq_low                 <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_i)
      REG_ENABLE:   rdata_o = {{(DATA_W-1){1'b0}}, cfg_o.en};
      REG_BASE_HI:  rdata_o = cfg_o.base[BASE_W-1:DATA_W];
      REG_BASE_LO:  rdata_o = cfg_o.base[DATA_W-1:0];
      REG_IRQ_NUM:  rdata_o = cfg_o.irq;
      REG_IRQ_TYPE: rdata_o = {{(DATA_W-1){1'b0}}, cfg_o.irq_low};
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ldev_cfg_port.sv
module ldev_cfg_port
  import ldev_cfg_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 16'h002E,
  parameter logic [ADDR_W-1:0] DAT_PORT = 16'h002F
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      io_wr_i,
  input  logic                      io_rd_i,
  input  logic [ADDR_W-1:0]         io_addr_i,
  input  logic [DATA_W-1:0]         io_wdata_i,
  output logic [DATA_W-1:0]         io_rdata_o,
  output logic [NUM_DEV-1:0]        dev_en_o,
  output logic [NUM_DEV*BASE_W-1:0] dev_base_o,
  output logic [NUM_DEV*IRQ_W-1:0]  dev_irq_num_o,
  output logic [NUM_DEV-1:0]        dev_irq_low_o
);
  logic              idx_sel, dat_sel, idx_wr, dat_wr;
  logic              unlocked;
  logic [DATA_W-1:0] index_q, ldn_q, reg_rdata;
  logic [NUM_DEV-1:0] bank_hit;
  logic [DATA_W-1:0] bank_rdata [NUM_DEV];

  assign idx_sel = (io_addr_i == IDX_PORT);
  assign dat_sel = (io_addr_i == DAT_PORT);
  assign idx_wr  = io_wr_i && idx_sel;
  assign dat_wr  = io_wr_i && dat_sel && unlocked;

  ldev_cfg_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (idx_wr),
    .wdata_i    (io_wdata_i),
    .unlocked_o (unlocked),
    .index_o    (index_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ldn_q <= '0;
    else if (dat_wr && index_q == REG_LDN) ldn_q <= io_wdata_i;
  end

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_bank
    dev_cfg_t cfg;
    assign bank_hit[i] = (ldn_q == DEV_ID[i]);

    ldev_cfg_bank u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (dat_wr && bank_hit[i]),
      .reg_i   (index_q),
      .wdata_i (io_wdata_i),
      .rdata_o (bank_rdata[i]),
      .cfg_o   (cfg)
    );

    assign dev_en_o[i]                      = cfg.en;
    assign dev_base_o[i*BASE_W +: BASE_W]   = cfg.base;
    assign dev_irq_num_o[i*IRQ_W +: IRQ_W]  = cfg.irq;
    assign dev_irq_low_o[i]                 = cfg.irq_low;
  end

  always_comb begin
    reg_rdata = '0;
    if (index_q == REG_LDN) begin
      reg_rdata = ldn_q;
    end else begin
      for (int i = 0; i < NUM_DEV; i++)
        if (bank_hit[i]) reg_rdata = reg_rdata | bank_rdata[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_rdata_o <= '0;
    end else if (io_rd_i) begin
      if (dat_sel)      io_rdata_o <= unlocked ? reg_rdata : LOCKED_READ;
      else if (idx_sel) io_rdata_o <= unlocked ? index_q : LOCKED_READ;
      else              io_rdata_o <= '0;
    end
  end
endmodule

// File: rtl/ldev_cfg_port_chk.sv
module ldev_cfg_port_chk
  import ldev_cfg_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 16'h002E,
  parameter logic [ADDR_W-1:0] DAT_PORT = 16'h002F
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      io_wr_i,
  input logic                      io_rd_i,
  input logic [ADDR_W-1:0]         io_addr_i,
  input logic [DATA_W-1:0]         io_wdata_i,
  input logic [DATA_W-1:0]         io_rdata_o,
  input logic [NUM_DEV-1:0]        dev_en_o,
  input logic [NUM_DEV*BASE_W-1:0] dev_base_o,
  input logic [NUM_DEV*IRQ_W-1:0]  dev_irq_num_o,
  input logic [NUM_DEV-1:0]        dev_irq_low_o,
  input logic                      unlocked,
  input logic [NUM_DEV-1:0]        bank_hit
);
  a_r5_locked_read_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && io_addr_i == DAT_PORT && !unlocked) |=> io_rdata_o == LOCKED_READ);

  a_r5_locked_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == DAT_PORT && !unlocked) |=>
      ($stable(dev_en_o) && $stable(dev_base_o) && $stable(dev_irq_num_o) && $stable(dev_irq_low_o)));

  a_r3_bad_key_stays_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == IDX_PORT && !unlocked && io_wdata_i != KEY_OPEN) |=> !unlocked);

  a_r4_close_key_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == IDX_PORT && unlocked && io_wdata_i == KEY_CLOSE) |=> !unlocked);

  a_r2_foreign_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i != IDX_PORT && io_addr_i != DAT_PORT) |=>
      ($stable(unlocked) && $stable(dev_en_o) && $stable(dev_base_o) &&
       $stable(dev_irq_num_o) && $stable(dev_irq_low_o)));

  a_r10_single_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_hit));

  a_r12_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |=> $stable(io_rdata_o));
endmodule

bind ldev_cfg_port ldev_cfg_port_chk #(
  .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .io_wr_i       (io_wr_i),
  .io_rd_i       (io_rd_i),
  .io_addr_i     (io_addr_i),
  .io_wdata_i    (io_wdata_i),
  .io_rdata_o    (io_rdata_o),
  .dev_en_o      (dev_en_o),
  .dev_base_o    (dev_base_o),
  .dev_irq_num_o (dev_irq_num_o),
  .dev_irq_low_o (dev_irq_low_o),
  .unlocked      (unlocked),
  .bank_hit      (bank_hit)
);

// File: tb/ldev_cfg_port_tb.sv
module ldev_cfg_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 9;
  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;
  localparam logic [7:0] DEVNUM [NDEV] = '{8'h02, 8'h03, 8'h04, 8'h05, 8'h07,
                                           8'h0B, 8'h0C, 8'h0D, 8'h0E};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NDEV-1:0] en_o, low_o;
  logic [NDEV*16-1:0] base_o;
  logic [NDEV*8-1:0] irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic        exp_en [NDEV];
  logic [15:0] exp_base [NDEV];
  logic [7:0]  exp_irq [NDEV];
  logic        exp_low [NDEV];

  always #(CLK_PERIOD/2) clk = ~clk;

  ldev_cfg_port u_dut (
    .clk_i (clk), .rst_ni (rst_n), .io_wr_i (wr), .io_rd_i (rd),
    .io_addr_i (addr), .io_wdata_i (wdata), .io_rdata_o (rdata),
    .dev_en_o (en_o), .dev_base_o (base_o), .dev_irq_num_o (irq_o),
    .dev_irq_low_o (low_o)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic cfg_wr(input logic [7:0] r, input logic [7:0] v);
    io_write(IDX, r);
    io_write(DAT, v);
  endtask

  task automatic cfg_rd(input logic [7:0] r, output logic [7:0] v);
    io_write(IDX, r);
    io_read(DAT, v);
  endtask

  task automatic check_outputs(input string tag);
    for (int i = 0; i < NDEV; i++) begin
      chk({15'd0, en_o[i]}, {15'd0, exp_en[i]}, {tag, " en"});
      chk(base_o[i*16 +: 16], exp_base[i], {tag, " base"});
      chk({8'd0, irq_o[i*8 +: 8]}, {8'd0, exp_irq[i]}, {tag, " irq"});
      chk({15'd0, low_o[i]}, {15'd0, exp_low[i]}, {tag, " low"});
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int i = 0; i < NDEV; i++) begin
      exp_en[i] = 1'b0; exp_base[i] = '0; exp_irq[i] = '0; exp_low[i] = 1'b0;
    end
    check_outputs("R1 reset");
    chk({8'd0, rdata}, 16'h0000, "R1 reset rdata");
    io_read(DAT, v); chk({8'd0, v}, 16'h00FF, "R5 locked data read");
    io_read(IDX, v); chk({8'd0, v}, 16'h00FF, "R5 locked index read");
  endtask

  task automatic t_locked_write();
    io_write(IDX, 8'h30);
    io_write(DAT, 8'h5A);
    check_outputs("R5 locked write");
  endtask

  task automatic t_unlock();
    logic [7:0] v;
    io_write(IDX, 8'hA5);
    io_write(IDX, 8'h12);
    io_write(IDX, 8'hA5);
    io_read(DAT, v); chk({8'd0, v}, 16'h00FF, "R3 restart keeps lock");
    io_write(IDX, 8'hA5);
    io_read(IDX, v); chk({8'd0, v}, 16'h0000, "R3 open, keys not stored");
    io_write(IDX, 8'h61);
    io_read(IDX, v); chk({8'd0, v}, 16'h0061, "R4 index readback");
  endtask

  task automatic t_program();
    logic [7:0] v;
    for (int i = 0; i < NDEV; i++) begin
      exp_en[i]   = ~i[0];
      exp_base[i] = 16'h1000 + 16'(i) * 16'h0123;
      exp_irq[i]  = 8'(i + 3);
      exp_low[i]  = i[1];
      cfg_wr(8'h07, DEVNUM[i]);
      cfg_wr(8'h30, {7'b1111000, exp_en[i]});
      cfg_wr(8'h60, exp_base[i][15:8]);
      cfg_wr(8'h61, exp_base[i][7:0]);
      cfg_wr(8'h70, exp_irq[i]);
      cfg_wr(8'h71, {7'b0, exp_low[i]});
    end
    check_outputs("R10 slots");
    for (int i = 0; i < NDEV; i++) begin
      cfg_wr(8'h07, DEVNUM[i]);
      cfg_rd(8'h07, v); chk({8'd0, v}, {8'd0, DEVNUM[i]}, "R6 ldn readback");
      cfg_rd(8'h30, v); chk({8'd0, v}, {15'd0, exp_en[i]}, "R7 enable readback");
      cfg_rd(8'h60, v); chk({8'd0, v}, {8'd0, exp_base[i][15:8]}, "R8 base hi");
      cfg_rd(8'h61, v); chk({8'd0, v}, {8'd0, exp_base[i][7:0]}, "R8 base lo");
      cfg_rd(8'h70, v); chk({8'd0, v}, {8'd0, exp_irq[i]}, "R9 irq num");
      cfg_rd(8'h71, v); chk({8'd0, v}, {15'd0, exp_low[i]}, "R9 irq type");
    end
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    cfg_wr(8'h07, 8'h06);
    cfg_rd(8'h07, v); chk({8'd0, v}, 16'h0006, "R6 unimplemented ldn stored");
    cfg_wr(8'h30, 8'h01);
    cfg_wr(8'h60, 8'hEE);
    cfg_rd(8'h30, v); chk({8'd0, v}, 16'h0000, "R11 unimpl device read");
    check_outputs("R11 unimpl device write");
    cfg_wr(8'h07, 8'h02);
    cfg_wr(8'h40, 8'h77);
    cfg_rd(8'h40, v); chk({8'd0, v}, 16'h0000, "R11 unimpl register read");
    cfg_rd(8'h62, v); chk({8'd0, v}, 16'h0000, "R11 register 0x62 read");
    check_outputs("R11 unimpl register write");
  endtask

  task automatic t_other_addr();
    logic [7:0] v;
    io_write(IDX, 8'h70);
    io_write(16'h0080, 8'hAA);
    io_write(16'h012E, 8'h55);
    io_read(IDX, v); chk({8'd0, v}, 16'h0070, "R2 foreign write ignored");
    check_outputs("R2 foreign write outputs");
    io_read(16'h0080, v); chk({8'd0, v}, 16'h0000, "R2 foreign read");
  endtask

  task automatic t_rdata_hold();
    logic [7:0] v;
    cfg_wr(8'h07, 8'h0E);
    cfg_rd(8'h70, v); chk({8'd0, v}, {8'd0, exp_irq[8]}, "R12 read value");
    repeat (3) @(negedge clk);
    chk({8'd0, rdata}, {8'd0, exp_irq[8]}, "R12 read data held");
  endtask

  task automatic t_relock();
    logic [7:0] v;
    io_write(IDX, 8'h61);
    io_write(IDX, 8'hAA);
    io_read(DAT, v); chk({8'd0, v}, 16'h00FF, "R4 relocked data read");
    io_read(IDX, v); chk({8'd0, v}, 16'h00FF, "R4 relocked index read");
    io_write(DAT, 8'h00);
    check_outputs("R5 write after relock");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked_write();
    t_unlock();
    t_program();
    t_unimpl();
    t_other_addr();
    t_rdata_hold();
    t_relock();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule